// File: doc/BRIEF.md
# Delay Tap Register Controller

This block keeps the 9-bit delay tap settings for two paths of a nibble-wide I/O slice: the data output path and the tristate-enable path. A simple register bus with separate write and read strobes reaches them. Each write to a tap register carries a 3-bit control code in the top bits of the write word. The code chooses one of three actions: load the 9-bit data field as the new tap, move the tap by one, or move the tap by a coarse amount. The coarse amount is held in a third register that software can read and write.

All tap arithmetic is modulo 512, so stepping past either end of the range wraps around. Reads are registered and return the current tap value in the low bits. The control bits and reserved bits always read back as zero. The delay line and the pads themselves are outside this block. It only drives the two tap values to them.

Top module: `delay_tap_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both taps become 0x000, the coarse-step register becomes 0x001, and `rdata` and `rd_valid` become zero.
- R2: A write to a tap register with code {wdata[15], wdata[14], wdata[13]} equal to 000, 001, 110 or 111 loads wdata[8:0] as the new tap.
- R3: Code 100 adds one to the tap, and 0x1FF goes to 0x000. The data field is ignored.
- R4: Code 010 subtracts one from the tap, and 0x000 goes to 0x1FF. The data field is ignored.
- R5: Code 101 adds the coarse-step value to the tap, modulo 512.
- R6: Code 011 subtracts the coarse-step value from the tap, modulo 512.
- R7: The coarse-step register at address 0x0C takes wdata[8:0] on every write, whatever the code bits are, and reads back its value.
- R8: A read strobe at address 0x0A (tristate tap), 0x0B (output tap) or 0x0C (coarse step) gives, one cycle later, `rd_valid` high and `rdata` holding the value before any write in the same cycle in bits [8:0], with bits [15:9] zero. Without a read strobe, `rdata` is zero and `rd_valid` is low.
- R9: Writes to any other address change nothing. Reads from any other address return zero with `rd_valid` high.
- R10: A write to one register leaves the other two unchanged.
- R11: A tap changes only at the clock edge that samples the write strobe. The new value is on the tap output right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write word: code bits [15:13], data [8:0] |
| rdata | output | 16 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read strobe |
| out_tap | output | 9 | Output-path delay tap |
| tri_tap | output | 9 | Tristate-path delay tap |

## Verification
The assertions check on every cycle the step arithmetic of the output tap for all four step codes, including wraparound. They also check that the taps hold when no write addresses them, that reads keep the upper bits at zero, and that unmapped reads return zero. Some behaviour can only be shown by the bench's scenarios: that every start value loads and steps correctly on the tristate path, that the coarse register ignores the code bits, that reads return pre-write values, and that a mix of coarse amounts and start points gives the arithmetically expected taps.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  // {inc, dec, coarse} control code carried on tap writes
  typedef enum logic [2:0] {
    CODE_LOAD_A = 3'b000,
    CODE_LOAD_B = 3'b001,
    CODE_DN_CRS = 3'b011,
    CODE_DN_ONE = 3'b010,
    CODE_UP_ONE = 3'b100,
    CODE_UP_CRS = 3'b101,
    CODE_LOAD_C = 3'b110,
    CODE_LOAD_D = 3'b111
  } step_code_e;
endpackage

// File: rtl/dtc_step_unit.sv
module dtc_step_unit
  import dtc_pkg::*;
#(
  parameter int TAP_W = 9
) (
  input  logic [TAP_W-1:0] cur,
  input  logic [TAP_W-1:0] load_val,
  input  logic [TAP_W-1:0] coarse,
  input  step_code_e       code,
  output logic [TAP_W-1:0] nxt
);
  // All arithmetic is naturally modulo 2**TAP_W by width truncation
  always_comb begin
    case (code)
      CODE_UP_ONE: nxt = cur + TAP_W'(1);
      CODE_DN_ONE: nxt = cur - TAP_W'(1);
      CODE_UP_CRS: nxt = cur + coarse;
      CODE_DN_CRS: nxt = cur - coarse;
      default:     nxt = load_val;
    endcase
  end
endmodule

// File: rtl/dtc_tap_channel.sv
module dtc_tap_channel
  import dtc_pkg::*;
#(
  parameter int              TAP_W   = 9,
  parameter logic [TAP_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  step_code_e       code,
  input  logic [TAP_W-1:0] load_val,
  input  logic [TAP_W-1:0] coarse,
  output logic [TAP_W-1:0] tap
);
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] tap_nxt;

  dtc_step_unit #(.TAP_W(TAP_W)) u_step (
    .cur      (tap_q),
    .load_val (load_val),
    .coarse   (coarse),
    .code     (code),
    .nxt      (tap_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)     tap_q <= RST_VAL;
    else if (we) tap_q <= tap_nxt;
  end

  assign tap = tap_q;
endmodule

// File: rtl/dtc_readback.sv
module dtc_readback #(
  parameter int DATA_W = 16,
  parameter int TAP_W  = 9,
  parameter int NSRC   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [NSRC-1:0]            hit,
  input  logic [NSRC-1:0][TAP_W-1:0] vals,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rd_valid
);
  logic [TAP_W-1:0]  sel_val;
  logic [DATA_W-1:0] rdata_q;
  logic              valid_q;

  // hit is one-hot or zero; OR-reduce keeps the mux shallow
  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NSRC; i++) begin
      sel_val = sel_val | (vals[i] & {TAP_W{hit[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
      rdata_q <= rd_en ? {{(DATA_W-TAP_W){1'b0}}, sel_val} : '0;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/delay_tap_ctrl.sv
module delay_tap_ctrl
  import dtc_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 16,
  parameter int               TAP_W      = 9,
  parameter logic [ADDR_W-1:0] ADDR_TRI   = 8'h0A,
  parameter logic [ADDR_W-1:0] ADDR_OUT   = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_STEP  = 8'h0C,
  parameter logic [TAP_W-1:0]  STEP_RESET = 9'h001,
  parameter int               INC_BIT    = 15,
  parameter int               DEC_BIT    = 14,
  parameter int               CRS_BIT    = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic [TAP_W-1:0]  out_tap,
  output logic [TAP_W-1:0]  tri_tap
);
  localparam int NCH  = 2;        // tap channels: 0 tristate, 1 output
  localparam int NSRC = NCH + 1;  // plus coarse-step register
  localparam logic [NSRC-1:0][ADDR_W-1:0] SRC_ADDR = {ADDR_STEP, ADDR_OUT, ADDR_TRI};

  logic [NSRC-1:0]            hit;
  logic [NSRC-1:0][TAP_W-1:0] vals;
  logic [TAP_W-1:0]           step_q;
  logic [TAP_W-1:0]           load_val;
  step_code_e                 code;
  logic                       dtc_unused;

  assign code       = step_code_e'({wdata[INC_BIT], wdata[DEC_BIT], wdata[CRS_BIT]});
  assign load_val   = wdata[TAP_W-1:0];
  assign dtc_unused = ^wdata[DATA_W-1:TAP_W];

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_dec
      assign hit[g] = (addr == SRC_ADDR[g]);
    end
    for (g = 0; g < NCH; g++) begin : g_ch
      dtc_tap_channel #(.TAP_W(TAP_W), .RST_VAL('0)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en & hit[g]),
        .code     (code),
        .load_val (load_val),
        .coarse   (step_q),
        .tap      (vals[g])
      );
    end
  endgenerate

  // Coarse-step register: same channel with the code pinned to a load
  dtc_tap_channel #(.TAP_W(TAP_W), .RST_VAL(STEP_RESET)) u_step_reg (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_en & hit[NCH]),
    .code     (CODE_LOAD_A),
    .load_val (load_val),
    .coarse   ('0),
    .tap      (step_q)
  );
  assign vals[NCH] = step_q;

  dtc_readback #(.DATA_W(DATA_W), .TAP_W(TAP_W), .NSRC(NSRC)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .hit      (hit),
    .vals     (vals),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  assign tri_tap = vals[0];
  assign out_tap = vals[1];
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 16,
  parameter int               TAP_W     = 9,
  parameter logic [ADDR_W-1:0] ADDR_TRI  = 8'h0A,
  parameter logic [ADDR_W-1:0] ADDR_OUT  = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_STEP = 8'h0C
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid,
  input logic [TAP_W-1:0]  out_tap,
  input logic [TAP_W-1:0]  tri_tap,
  input logic [TAP_W-1:0]  step_q
);
  logic       wr_out;
  logic       mapped;
  logic [2:0] code;
  assign wr_out = wr_en && (addr == ADDR_OUT);
  assign mapped = (addr == ADDR_TRI) || (addr == ADDR_OUT) || (addr == ADDR_STEP);
  assign code   = wdata[DATA_W-1 -: 3];

  AST_RESET_TAPS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_tap == '0 && tri_tap == '0)); // R1

  AST_UP_ONE: assert property (@(posedge clk) disable iff (rst)
    (wr_out && code == 3'b100) |=> out_tap == TAP_W'($past(out_tap) + 1'b1)); // R3

  AST_DN_ONE: assert property (@(posedge clk) disable iff (rst)
    (wr_out && code == 3'b010) |=> out_tap == TAP_W'($past(out_tap) - 1'b1)); // R4

  AST_UP_CRS: assert property (@(posedge clk) disable iff (rst)
    (wr_out && code == 3'b101) |=> out_tap == TAP_W'($past(out_tap) + $past(step_q))); // R5

  AST_DN_CRS: assert property (@(posedge clk) disable iff (rst)
    (wr_out && code == 3'b011) |=> out_tap == TAP_W'($past(out_tap) - $past(step_q))); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_out |=> $stable(out_tap)); // R10

  AST_TRI_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_TRI) |=> $stable(tri_tap)); // R10

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rdata[DATA_W-1:TAP_W] == '0); // R8

  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rd_valid && rdata == '0)); // R9
endmodule

bind delay_tap_ctrl dtc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAP_W(TAP_W),
  .ADDR_TRI(ADDR_TRI), .ADDR_OUT(ADDR_OUT), .ADDR_STEP(ADDR_STEP)
) u_dtc_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
  .out_tap(out_tap), .tri_tap(tri_tap), .step_q(step_q)
);

// File: tb/tb_delay_tap_ctrl.sv
module tb_delay_tap_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic [8:0]  out_tap;
  logic [8:0]  tri_tap;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  delay_tap_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .out_tap(out_tap), .tri_tap(tri_tap)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v, output int vld);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata); vld = int'(rd_valid);
  endtask

  function automatic int wrap(input int x);
    return ((x % 512) + 512) % 512;
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v, vld, a;
    int steps[6]  = '{0, 1, 5, 100, 256, 511};
    int starts[4] = '{0, 3, 300, 511};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_tap", out_tap, 0);
    chk("R1 tri_tap", tri_tap, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rst = 1'b0;
    rd(8'h0C, v, vld); chk("R1 step reset", v, 1);

    // Sweep every start value on the tristate path
    for (int s = 0; s < 512; s++) begin
      wr(8'h0A, 16'h0000 | 16'(s));
      chk("R2 load 000", tri_tap, s);
      wr(8'h0A, 16'h8000 | 16'(s ^ 9'h155));
      chk("R3 inc one", tri_tap, wrap(s + 1));
      wr(8'h0A, 16'h4000 | 16'(s ^ 9'h0AA));
      wr(8'h0A, 16'h4000);
      chk("R4 dec one", tri_tap, wrap(s - 1));
      chk("R10 out untouched", out_tap, 0);
    end

    // Other load codes on the output path
    wr(8'h0B, 16'h2000 | 16'h0123); chk("R2 load 001", out_tap, 9'h123);
    wr(8'h0B, 16'hC000 | 16'h01FE); chk("R2 load 110", out_tap, 9'h1FE);
    wr(8'h0B, 16'hE000 | 16'h0007); chk("R2 load 111", out_tap, 9'h007);
    wr(8'h0B, 16'h1E00 | 16'h0042); chk("R2 reserved bits", out_tap, 9'h042);

    // Coarse steps, with code bits set on the step write (R7)
    foreach (steps[i]) begin
      wr(8'h0C, 16'hE000 | 16'(steps[i]));
      rd(8'h0C, v, vld); chk("R7 step readback", v, steps[i]);
      foreach (starts[j]) begin
        wr(8'h0B, 16'(starts[j]));
        wr(8'h0B, 16'hA000 | 16'h01FF);
        chk("R5 coarse up", out_tap, wrap(starts[j] + steps[i]));
        wr(8'h0B, 16'h6000);
        wr(8'h0B, 16'h6000);
        chk("R6 coarse down", out_tap, wrap(starts[j] - steps[i]));
      end
    end

    // R8 readback and R10 independence
    wr(8'h0A, 16'h0155);
    wr(8'h0B, 16'h00AA);
    wr(8'h0C, 16'h0033);
    chk("R10 tri after others", tri_tap, 9'h155);
    rd(8'h0A, v, vld); chk("R8 tri read", v, 9'h155); chk("R8 rd_valid", vld, 1);
    rd(8'h0B, v, vld); chk("R8 out read", v, 9'h0AA);
    @(negedge clk);
    chk("R8 idle rdata", rdata, 0); chk("R8 idle valid", rd_valid, 0);
    // read and write together: read returns pre-write value
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h0B; wdata = 16'h0111;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R8 read before write", rdata, 9'h0AA);
    chk("R8 write landed", out_tap, 9'h111);

    // R9 unmapped writes and reads
    a = 0;
    foreach (steps[i]) begin
      logic [7:0] ua;
      ua = (i % 2 == 0) ? 8'(9 + i) : 8'(8'hF0 + i);
      if (ua == 8'h0A || ua == 8'h0B || ua == 8'h0C) ua = 8'h0D;
      wr(ua, 16'h8000 | 16'h01FF);
      rd(ua, v, vld);
      chk("R9 unmapped read", v, 0); chk("R9 unmapped valid", vld, 1);
    end
    chk("R9 tri intact", tri_tap, 9'h155);
    chk("R9 out intact", out_tap, 9'h111);
    rd(8'h0C, v, vld); chk("R9 step intact", v, 9'h033);

    // R11 timing of the update
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h0B; wdata = 16'h0040;
    #1 chk("R11 before edge", out_tap, 9'h111);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 after edge", out_tap, 9'h040);

    // R1 reset again from non-zero state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 out re-reset", out_tap, 0);
    chk("R1 tri re-reset", tri_tap, 0);
    rd(8'h0C, v, vld); chk("R1 step re-reset", v, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule